// File: doc/BRIEF.md
# Set/Clear DMA Enable Controller

This block holds a 16-bit DMA control word that software changes with set/clear writes. Bit 15 of each write is a mode selector and is never stored. With it high, the other one bits of the write turn the matching register bits on. With it low, they turn those bits off. In both modes the zero bits of the write leave the register alone, so one write can change a single enable without a read-modify-write.

The block drives four audio DMA channels. Each channel's effective enable is its own channel bit ANDed with a master enable bit. Each channel also has a sample-period tick input. While the channel is not running, the block counts that channel's ticks, saturating at two. When the channel runs again, the count decides its fate. If two or more ticks passed, the block raises a one-cycle restart pulse, which tells the fetch engine to reload the pointer and length and start again from the head of the data list. If fewer than two ticks passed, the channel continues from where it stopped. The fetch engine, the sample output and the other DMA sources that share the word are outside this block.

Top module: `dma_enable_ctl`

## Requirements
- R1: A write with bit 15 = 1 sets every register bit in positions 14..0 where the write data is 1. It changes no other bit.
- R2: A write with bit 15 = 0 clears every register bit where the write data is 1. It changes no other bit.
- R3: Register bits whose write-data bit is 0 keep their value. Bits outside 15, 9 and 3..0 (for example 5 and 4) are stored and read back unchanged.
- R4: Reset clears the whole register to 0x0000. Bit 15 is not stored and always reads 0, so a write of only bit 15 changes nothing.
- R5: Bit 9 is the master enable. Bits 0, 1, 2 and 3 enable channels 0, 1, 2 and 3. Channel i's effective enable is bit i AND bit 9. It changes in the cycle after the write that sets or clears either bit.
- R6: A single write of 0x8201 turns on the master enable and channel 0 together. Channel 0 is active from the next cycle.
- R7: If a channel was inactive for two or more of its own ticks, its restart output is high for exactly one cycle: the first cycle the channel is active again.
- R8: If a channel was inactive for fewer than two of its own ticks, it becomes active again with no restart pulse.
- R9: The first time a channel becomes active after reset, it gives a restart pulse. No ticks are needed for this.
- R10: Ticks that arrive while a channel is active are ignored. Ticks for one channel do not count toward another channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the control word |
| wrData | input | 16 | Write data; bit 15 selects set (1) or clear (0) |
| rdData | output | 16 | Current register value; bit 15 always 0 |
| sampleTick | input | 4 | Per-channel sample-period tick |
| chanActive | output | 4 | Per-channel effective enable (channel bit AND master) |
| restartPulse | output | 4 | One-cycle per-channel request to reload pointer and length |

## Verification
A wrong register bit shows on rdData one cycle after the write that caused it. If the bit is an enable, chanActive also goes wrong in that same cycle. A wrong gap counter stays hidden until the channel turns on again. It then shows up as a missing restart pulse or an extra one, in the first cycle chanActive rises. The bench therefore ends every gap scenario with a re-enable and samples the restart output in exactly that cycle.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;
  localparam int REG_W      = 16;
  localparam int CH_N       = 4;
  localparam int SEL_BIT    = 15;
  localparam int MASTER_BIT = 9;
  localparam int GAP_LIMIT  = 2;
  localparam int GAP_W      = $clog2(GAP_LIMIT + 1);

  // Strobes from control to datapath
  typedef struct packed {
    logic [REG_W-1:0] setMask;
    logic [REG_W-1:0] clrMask;
    logic [CH_N-1:0]  gapInc;
    logic [CH_N-1:0]  gapClr;
  } ctlStrobe_t;

  // Status from datapath to control
  typedef struct packed {
    logic [CH_N-1:0] active;
    logic [CH_N-1:0] activeQ;
    logic [CH_N-1:0] gapFull;
  } dpStatus_t;
endpackage

// File: rtl/dma_ctl_datapath.sv
module dma_ctl_datapath
  import dma_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobe,
  output logic [REG_W-1:0] regQ,
  output dpStatus_t        status
);
  localparam logic [GAP_W-1:0] GAP_TOP = GAP_W'(GAP_LIMIT);

  logic [CH_N-1:0] activeNow;
  logic [CH_N-1:0] activeDly;
  logic [CH_N-1:0] gapFullVec;

  always_ff @(posedge clk) begin
    if (!rstN) regQ <= '0;
    else       regQ <= (regQ & ~strobe.clrMask) | strobe.setMask;
  end

  assign activeNow = regQ[CH_N-1:0] & {CH_N{regQ[MASTER_BIT]}};

  always_ff @(posedge clk) begin
    if (!rstN) activeDly <= '0;
    else       activeDly <= activeNow;
  end

  // Per-channel gap counter; starts full so the first enable restarts
  for (genvar ch = 0; ch < CH_N; ch++) begin : gGap
    logic [GAP_W-1:0] gapCnt;
    always_ff @(posedge clk) begin
      if (!rstN)                                   gapCnt <= GAP_TOP;
      else if (strobe.gapClr[ch])                  gapCnt <= '0;
      else if (strobe.gapInc[ch] && gapCnt != GAP_TOP) gapCnt <= gapCnt + 1'b1;
    end
    assign gapFullVec[ch] = (gapCnt == GAP_TOP);
  end

  assign status.active  = activeNow;
  assign status.activeQ = activeDly;
  assign status.gapFull = gapFullVec;
endmodule

// File: rtl/dma_ctl_control.sv
module dma_ctl_control
  import dma_ctl_pkg::*;
(
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic [CH_N-1:0]  sampleTick,
  input  dpStatus_t        status,
  output ctlStrobe_t       strobe,
  output logic [CH_N-1:0]  restartPulse
);
  localparam logic [REG_W-1:0] STORE_MASK = ~(REG_W'(1) << SEL_BIT);

  logic setMode;
  logic clrMode;

  assign setMode = wrEn &  wrData[SEL_BIT];
  assign clrMode = wrEn & ~wrData[SEL_BIT];

  always_comb begin
    strobe.setMask = setMode ? (wrData & STORE_MASK) : '0;
    strobe.clrMask = clrMode ? wrData : '0;
    strobe.gapInc  = sampleTick & ~status.active;
    strobe.gapClr  = status.active;
  end

  for (genvar ch = 0; ch < CH_N; ch++) begin : gRestart
    assign restartPulse[ch] = status.active[ch] & ~status.activeQ[ch] & status.gapFull[ch];
  end
endmodule

// File: rtl/dma_enable_ctl.sv
module dma_enable_ctl
  import dma_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  input  logic [CH_N-1:0]  sampleTick,
  output logic [CH_N-1:0]  chanActive,
  output logic [CH_N-1:0]  restartPulse
);
  ctlStrobe_t strobe;
  dpStatus_t  status;

  dma_ctl_control u_ctl (
    .wrEn(wrEn), .wrData(wrData), .sampleTick(sampleTick),
    .status(status), .strobe(strobe), .restartPulse(restartPulse)
  );

  dma_ctl_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regQ(rdData), .status(status)
  );

  assign chanActive = status.active;
endmodule

// File: rtl/dma_enable_ctl_chk.sv
module dma_enable_ctl_chk
  import dma_ctl_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [REG_W-1:0] wrData,
  input logic [REG_W-1:0] rdData,
  input logic [CH_N-1:0]  chanActive,
  input logic [CH_N-1:0]  restartPulse
);
  localparam logic [REG_W-1:0] KEEP = ~(REG_W'(1) << SEL_BIT);

  AST_SET_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[SEL_BIT]) |=> ((rdData & $past(wrData) & KEEP) == ($past(wrData) & KEEP))); // R1

  AST_CLR_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrData[SEL_BIT]) |=> ((rdData & $past(wrData)) == '0)); // R2

  AST_UNTOUCHED_BITS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (((rdData ^ $past(rdData)) & ~($past(wrData) & {REG_W{$past(wrEn)}})) == '0)); // R3

  AST_SEL_NOT_STORED: assert property (@(posedge clk) disable iff (!rstN)
    rdData[SEL_BIT] == 1'b0); // R4

  AST_MASTER_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !rdData[MASTER_BIT] |-> (chanActive == '0)); // R5

  AST_RESTART_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((restartPulse & ~(chanActive & ~$past(chanActive))) == '0)); // R7

  AST_RESTART_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (restartPulse != '0) |=> ((restartPulse & $past(restartPulse)) == '0)); // R7
endmodule

bind dma_enable_ctl dma_enable_ctl_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
  .chanActive(chanActive), .restartPulse(restartPulse)
);

// File: tb/sim_dma_enable_ctl.sv
module sim_dma_enable_ctl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [3:0]  sampleTick = '0;
  logic [3:0]  chanActive;
  logic [3:0]  restartPulse;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dma_enable_ctl u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .sampleTick(sampleTick), .chanActive(chanActive), .restartPulse(restartPulse)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Write; returns at the negedge where the result is visible
  task automatic wr(input logic [15:0] d);
    @(negedge clk); wrEn = 1'b1; wrData = d;
    @(negedge clk); wrEn = 1'b0; wrData = '0;
  endtask

  task automatic tick(input logic [3:0] m, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); sampleTick = m;
      @(negedge clk); sampleTick = '0;
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic tReset();
    doReset();
    chk("R4 reset value", rdData, 16'h0000);
    chk("R4 reset active", {12'b0, chanActive}, 16'h0);
    chk("R4 reset restart", {12'b0, restartPulse}, 16'h0);
  endtask

  task automatic tFirstEnable();
    wr(16'h8201);
    chk("R6 readback", rdData, 16'h0201);
    chk("R6 active", {12'b0, chanActive}, 16'h1);
    chk("R9 first restart", {12'b0, restartPulse}, 16'h1);
    @(negedge clk);
    chk("R7 pulse one cycle", {12'b0, restartPulse}, 16'h0);
  endtask

  task automatic tSetKeep();
    wr(16'h8030);
    chk("R1 R3 set other bits", rdData, 16'h0231);
    wr(16'h8000);
    chk("R4 bit15 not stored", rdData, 16'h0231);
    chk("R3 active kept", {12'b0, chanActive}, 16'h1);
  endtask

  task automatic tTicksWhileActive();
    tick(4'h1, 2);
    wr(16'h0001);
    chk("R2 clear ch0", rdData, 16'h0230);
    chk("R5 ch0 off", {12'b0, chanActive}, 16'h0);
    wr(16'h8001);
    chk("R10 active ticks ignored", {12'b0, restartPulse}, 16'h0);
    chk("R8 resumes", {12'b0, chanActive}, 16'h1);
  endtask

  task automatic tShortGap();
    wr(16'h0001);
    tick(4'h1, 1);
    tick(4'h2, 3);
    wr(16'h8001);
    chk("R8 short gap no restart", {12'b0, restartPulse}, 16'h0);
    chk("R10 other channel ticks", {12'b0, chanActive}, 16'h1);
  endtask

  task automatic tLongGap();
    wr(16'h0001);
    tick(4'h1, 3);
    wr(16'h8001);
    chk("R7 long gap restart", {12'b0, restartPulse}, 16'h1);
    @(negedge clk);
    chk("R7 pulse cleared", {12'b0, restartPulse}, 16'h0);
  endtask

  task automatic tMaster();
    wr(16'h0200);
    chk("R5 master off", {12'b0, chanActive}, 16'h0);
    chk("R2 master bit clear", rdData, 16'h0031);
    tick(4'h1, 1);
    wr(16'h8200);
    chk("R5 master on", {12'b0, chanActive}, 16'h1);
    chk("R8 master short gap", {12'b0, restartPulse}, 16'h0);
  endtask

  task automatic tMapping();
    wr(16'h8004);
    chk("R5 ch2 map", {12'b0, chanActive}, 16'h5);
    chk("R9 ch2 first", {12'b0, restartPulse}, 16'h4);
    wr(16'h8008);
    chk("R5 ch3 map", {12'b0, chanActive}, 16'hD);
    chk("R9 ch3 first", {12'b0, restartPulse}, 16'h8);
    wr(16'h0030);
    chk("R2 R3 multi clear", rdData, 16'h020D);
    chk("R3 channels kept", {12'b0, chanActive}, 16'hD);
  endtask

  task automatic tMasterLongGap();
    wr(16'h0200);
    tick(4'hF, 2);
    wr(16'h8200);
    chk("R7 all restart", {12'b0, restartPulse}, 16'hD);
    chk("R5 all active", {12'b0, chanActive}, 16'hD);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tReset();
    tFirstEnable();
    tSetKeep();
    tTicksWhileActive();
    tShortGap();
    tLongGap();
    tMaster();
    tMapping();
    tMasterLongGap();
    tReset();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule